// File: doc/BRIEF.md
# Packet egress arbiter

This block sits at one output of a stream switch and decides which of its N input streams may drive that output. Each input is a valid/ready stream with data and an end-of-packet marker. The output is a single stream of the same kind. Allocation is made on the first beat of a packet within the same cycle, with no added latency. The chosen input then keeps the output until its end-of-packet beat has transferred, so packets from different inputs never interleave.

A parameter selects the allocation policy. In fixed-priority mode the waiting input with the smallest index wins. In rotating mode the search starts one position after the input that finished the most recent packet, wrapping modulo N, and the first waiting input found wins. A second parameter inserts an optional single register stage on the output. That stage still accepts one beat per cycle.

Top module: `pkt_egress_arbiter`

## Requirements
- R1: After reset, with no input valid and out_ready high, out_valid is low and in_ready is high for input 0 only (allocation and previous-winner both reset to input 0).
- R2: At most one in_ready bit is high in any cycle, and it belongs to the currently allocated input.
- R3: Once the first beat of a packet has transferred, the allocation stays fixed until a beat with last high transfers. Input idle cycles inside the packet do not release it, and no beat of another input appears at the output in between.
- R4: With ALLOC_MODE = ALLOC_FIXED, the allocation made at a packet start is the lowest-indexed input whose valid is high.
- R5: With ALLOC_MODE = ALLOC_ROTATE, the allocation made at a packet start is the first input with valid high, searching upward from (previous winner + 1) mod N.
- R6: The previous-winner register changes only when a beat with last high transfers, and a single-beat packet counts as a finished packet.
- R7: While no packet is in progress and no input is valid, the allocation keeps its last value, so in_ready shows the input of the last finished packet.
- R8: out_data and out_last carry exactly the beats of the allocated input, in order, with none lost or duplicated.
- R9: With OUT_REG = 1 a beat accepted in one cycle shows on out_valid from the next cycle, and beats still move at one per cycle. With OUT_REG = 0, out_valid follows the allocated input's valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | NUM_IN | Per-input beat valid |
| in_last | input | NUM_IN | Per-input end-of-packet marker |
| in_data | input | NUM_IN*DATA_W | Per-input data, input i at bits [i*DATA_W +: DATA_W] |
| in_ready | output | NUM_IN | Per-input ready, high only for the allocated input |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Output end-of-packet marker |
| out_data | output | DATA_W | Output data |
| out_ready | input | 1 | Downstream ready |

## Verification
If the head/body bit is wrong, a beat from a different input appears at out_data inside a packet, in the same cycle as the faulty state (one cycle later with the output register). A corrupt previous-winner register is seen only at the next packet start in rotating mode, where the source tag of the first beat of that packet is wrong. A corrupt allocation register shows up while the block is idle as in_ready on the wrong input, and it shows up on the next body beat as foreign data. The bench tags every beat with its source, phase, packet and beat number, so the scoreboard detects each of these on the first affected beat.

// File: rtl/egress_arb_pkg.sv
package egress_arb_pkg;

  // Position inside the packet currently owning the output
  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_BODY = 1'b1
  } pkt_phase_e;

  // Allocation policy
  typedef enum logic {
    ALLOC_FIXED  = 1'b0,
    ALLOC_ROTATE = 1'b1
  } alloc_mode_e;

endpackage

// File: rtl/egress_grant_sel.sv
// Combinational winner search over the request vector.
module egress_grant_sel
  import egress_arb_pkg::*;
#(
  parameter int unsigned NUM_IN     = 4,
  parameter int unsigned SEL_W      = 2,
  parameter alloc_mode_e ALLOC_MODE = ALLOC_ROTATE
) (
  input  logic [NUM_IN-1:0] req,
  input  logic [SEL_W-1:0]  prev_win,
  output logic [SEL_W-1:0]  grant,
  output logic              any_req
);

  assign any_req = |req;

  generate
    if (ALLOC_MODE == ALLOC_FIXED) begin : g_fixed
      // Walk downward so the smallest requesting index is written last
      always_comb begin
        grant = prev_win;
        for (int idx = NUM_IN - 1; idx >= 0; idx--) begin
          if (req[idx]) begin
            grant = SEL_W'(idx);
          end
        end
      end
    end else begin : g_rotate
      // Offsets 1..NUM_IN from the previous winner; smallest offset wins
      always_comb begin
        int unsigned cand;
        grant = prev_win;
        for (int off = NUM_IN; off >= 1; off--) begin
          cand = int'(prev_win) + off;
          if (cand >= NUM_IN) begin
            cand = cand - NUM_IN;
          end
          if (req[cand]) begin
            grant = SEL_W'(cand);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/egress_alloc_ctrl.sv
// Packet phase tracking plus the locked and previous-winner registers.
module egress_alloc_ctrl
  import egress_arb_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic [SEL_W-1:0] grant,
  input  logic             xfer,
  input  logic             xfer_last,
  output logic [SEL_W-1:0] cur_sel,
  output logic             at_head,
  output logic [SEL_W-1:0] prev_win
);

  pkt_phase_e       phase_q, phase_d;
  logic [SEL_W-1:0] lock_q, lock_d;
  logic [SEL_W-1:0] prev_q, prev_d;
  logic             phase_en, lock_en, prev_en;

  assign at_head  = (phase_q == PH_HEAD);
  assign prev_win = prev_q;

  // Fresh decision only at a packet start with someone waiting
  always_comb begin
    if (at_head && any_req) begin
      cur_sel = grant;
    end else begin
      cur_sel = lock_q;
    end
  end

  // Clock enables
  assign phase_en = xfer;
  assign lock_en  = xfer && at_head;
  assign prev_en  = xfer && xfer_last;

  // Next-state values
  always_comb begin
    phase_d = xfer_last ? PH_HEAD : PH_BODY;
    lock_d  = cur_sel;
    prev_d  = cur_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HEAD;
      lock_q  <= '0;
      prev_q  <= '0;
    end else begin
      if (phase_en) begin
        phase_q <= phase_d;
      end
      if (lock_en) begin
        lock_q <= lock_d;
      end
      if (prev_en) begin
        prev_q <= prev_d;
      end
    end
  end

  AST_PREV_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer && xfer_last) |=> $stable(prev_q)); // R6

  AST_BODY_AFTER_MID_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !xfer_last) |=> !at_head); // R3

endmodule

// File: rtl/egress_out_stage.sv
// Optional single output register that keeps one beat per cycle.
module egress_out_stage #(
  parameter int unsigned DATA_W  = 64,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_last,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  generate
    if (OUT_REG) begin : g_reg
      logic              full_q, full_d;
      logic              last_q;
      logic [DATA_W-1:0] data_q;
      logic              load;

      assign up_ready = !full_q || out_ready;
      assign load     = up_valid && up_ready;

      always_comb begin
        if (load) begin
          full_d = 1'b1;
        end else if (out_ready) begin
          full_d = 1'b0;
        end else begin
          full_d = full_q;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          last_q <= 1'b0;
          data_q <= '0;
        end else begin
          full_q <= full_d;
          if (load) begin
            last_q <= up_last;
            data_q <= up_data;
          end
        end
      end

      assign out_valid = full_q;
      assign out_last  = last_q;
      assign out_data  = data_q;

      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9

      AST_OUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> out_valid); // R9
    end else begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = &{1'b0, clk, rst_n};
      assign up_ready  = out_ready;
      assign out_valid = up_valid;
      assign out_last  = up_last;
      assign out_data  = up_data;
    end
  endgenerate

endmodule

// File: rtl/pkt_egress_arbiter.sv
// N-to-1 packet arbiter for one switch output.
module pkt_egress_arbiter
  import egress_arb_pkg::*;
#(
  parameter int unsigned NUM_IN     = 4,
  parameter int unsigned DATA_W     = 64,
  parameter alloc_mode_e ALLOC_MODE = ALLOC_ROTATE,
  parameter bit          OUT_REG    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        in_valid,
  input  logic [NUM_IN-1:0]        in_last,
  input  logic [NUM_IN*DATA_W-1:0] in_data,
  output logic [NUM_IN-1:0]        in_ready,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     out_ready
);

  localparam int unsigned SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [SEL_W-1:0]  grant;
  logic [SEL_W-1:0]  cur_sel;
  logic [SEL_W-1:0]  prev_win;
  logic              any_req;
  logic              at_head;
  logic              stage_ready;
  logic              mux_valid;
  logic              mux_last;
  logic [DATA_W-1:0] mux_data;
  logic              xfer;

  egress_grant_sel #(
    .NUM_IN     (NUM_IN),
    .SEL_W      (SEL_W),
    .ALLOC_MODE (ALLOC_MODE)
  ) u_sel (
    .req      (in_valid),
    .prev_win (prev_win),
    .grant    (grant),
    .any_req  (any_req)
  );

  egress_alloc_ctrl #(
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .grant     (grant),
    .xfer      (xfer),
    .xfer_last (mux_last),
    .cur_sel   (cur_sel),
    .at_head   (at_head),
    .prev_win  (prev_win)
  );

  // Data path: only the allocated input reaches the output stage
  always_comb begin
    mux_valid = in_valid[cur_sel];
    mux_last  = in_last[cur_sel];
    mux_data  = in_data[cur_sel*DATA_W +: DATA_W];
  end

  assign xfer = mux_valid && stage_ready;

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_ready
      assign in_ready[gi] = stage_ready && (cur_sel == SEL_W'(gi));
    end
  endgenerate

  egress_out_stage #(
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (mux_valid),
    .up_last   (mux_last),
    .up_data   (mux_data),
    .up_ready  (stage_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready)); // R2

  AST_BODY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mux_last) |=> (cur_sel == $past(cur_sel))); // R3

  AST_GRANT_IS_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (at_head && any_req) |-> in_valid[cur_sel]); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_head && !any_req) |=> (!at_head || (cur_sel == $past(cur_sel)) || any_req)); // R7

  generate
    if (ALLOC_MODE == ALLOC_FIXED) begin : g_fixed_chk
      logic [NUM_IN-1:0] below_mask;
      assign below_mask = (NUM_IN'(1) << cur_sel) - NUM_IN'(1);
      AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (at_head && any_req) |-> ((in_valid & below_mask) == '0)); // R4
    end
  endgenerate

endmodule

// File: tb/tb_pkt_egress_arbiter.sv
module tb_pkt_egress_arbiter;
  import egress_arb_pkg::*;

  localparam int N   = 4;
  localparam int W   = 16;
  localparam int NPH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad = 0;
  int ph = -1;
  int cyc = 0;
  int plen [NPH][N][2];
  int prev_m [2];
  int fin [2][N];
  logic or_pat_en = 1'b0;
  logic [W:0] expq [2][$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Scoreboard driver model: packet order from the allocation rules (R4, R5, R6)
  task automatic build_expect(input int k, input int f);
    int rem [N];
    int nxt [N];
    int left;
    int w;
    left = 0;
    for (int p = 0; p < N; p++) begin
      rem[p] = 0;
      nxt[p] = 0;
      for (int i = 0; i < 2; i++) if (plen[f][p][i] > 0) rem[p]++;
      left += rem[p];
    end
    while (left > 0) begin
      w = -1;
      if (k == 1) begin
        for (int p = 0; p < N; p++) if (w < 0 && rem[p] > 0) w = p;
      end else begin
        for (int o = 1; o <= N; o++) begin
          int c;
          c = (prev_m[k] + o) % N;
          if (w < 0 && rem[c] > 0) w = c;
        end
      end
      for (int b = 0; b < plen[f][w][nxt[w]]; b++) begin
        expq[k].push_back({(b == plen[f][w][nxt[w]] - 1), 2'(w), 2'(f), 2'(nxt[w]), 10'(b)});
      end
      nxt[w]++;
      rem[w]--;
      left--;
      prev_m[k] = w;
    end
  endtask

  generate
    for (genvar k = 0; k < 2; k++) begin : g_inst
      logic [N-1:0]   iv, il, ir;
      logic [N*W-1:0] id;
      logic           ov, ol, ordy;
      logic [W-1:0]   od;

      pkt_egress_arbiter #(
        .NUM_IN     (N),
        .DATA_W     (W),
        .ALLOC_MODE ((k == 0) ? ALLOC_ROTATE : ALLOC_FIXED),
        .OUT_REG    (k == 0)
      ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iv),
        .in_last   (il),
        .in_data   (id),
        .in_ready  (ir),
        .out_valid (ov),
        .out_last  (ol),
        .out_data  (od),
        .out_ready (ordy)
      );

      initial begin
        ordy = 1'b1;
        forever begin
          @(posedge clk);
          #1;
          ordy = or_pat_en ? (((cyc * 7 + k * 3) % 5) != 0) : 1'b1;
        end
      end

      for (genvar p = 0; p < N; p++) begin : g_drv
        logic         v, l;
        logic [W-1:0] d;
        assign iv[p]       = v;
        assign il[p]       = l;
        assign id[p*W +: W] = d;

        initial begin
          v = 1'b0; l = 1'b0; d = '0;
          for (int f = 0; f < NPH; f++) begin
            wait (ph == f);
            for (int i = 0; i < 2; i++) begin
              for (int b = 0; b < plen[f][p][i]; b++) begin
                // Idle cycles only inside a packet body (R3)
                if (b > 0 && ((p + i + b + k) % 3 == 0)) begin
                  v = 1'b0;
                  @(posedge clk);
                  #1;
                end
                v = 1'b1;
                l = (b == plen[f][p][i] - 1);
                d = {2'(p), 2'(f), 2'(i), 10'(b)};
                forever begin
                  @(negedge clk);
                  if (ir[p]) begin
                    @(posedge clk);
                    #1;
                    break;
                  end
                  @(posedge clk);
                  #1;
                end
              end
            end
            v = 1'b0;
            l = 1'b0;
            fin[k][p] = f;
          end
        end
      end

      // Monitor: compare output beats with the scoreboard (R3, R8, R4/R5)
      initial begin
        forever begin
          @(negedge clk);
          if (rst_n) begin
            check($countones(ir) <= 1, "R2 single ready", 32'(ir), 32'h1);
            if (ov && ordy) begin
              if (expq[k].size() == 0) begin
                check(1'b0, (k == 0) ? "R8 R5 unexpected beat" : "R8 R4 unexpected beat",
                      32'({ol, od}), 32'h0);
              end else begin
                logic [W:0] e;
                e = expq[k].pop_front();
                check({ol, od} == e, (k == 0) ? "R3 R8 R5 R6 beat" : "R3 R8 R4 beat",
                      32'({ol, od}), 32'(e));
              end
            end
          end
        end
      end
    end
  endgenerate

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    report();
    $finish;
  end

  initial begin
    for (int f = 0; f < NPH; f++)
      for (int p = 0; p < N; p++)
        for (int i = 0; i < 2; i++) plen[f][p][i] = 0;
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < 2; i++) plen[0][p][i] = 1 + (p + i) % 3;
      fin[0][p] = -1;
      fin[1][p] = -1;
    end
    plen[1][3][0] = 3;
    plen[2][0][0] = 2;
    plen[2][1][0] = 2;
    plen[2][2][0] = 1;
    plen[3][1][0] = 2;
    plen[3][3][0] = 2;
    prev_m[0] = 0;
    prev_m[1] = 0;

    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(g_inst[0].ov == 1'b0, "R1 out_valid after reset (reg)", 32'(g_inst[0].ov), 32'h0);
    check(g_inst[1].ov == 1'b0, "R1 out_valid after reset (pass)", 32'(g_inst[1].ov), 32'h0);
    check(g_inst[0].ir == 4'b0001, "R1 in_ready after reset (reg)", 32'(g_inst[0].ir), 32'h1);
    check(g_inst[1].ir == 4'b0001, "R1 in_ready after reset (pass)", 32'(g_inst[1].ir), 32'h1);

    for (int f = 0; f < NPH; f++) begin
      build_expect(0, f);
      build_expect(1, f);
      @(posedge clk);
      #1;
      or_pat_en = (f != 1);
      ph = f;
      @(negedge clk);
      // R9: registered output lags one cycle, pass-through follows at once
      check(g_inst[0].ov == 1'b0, "R9 registered stage first cycle", 32'(g_inst[0].ov), 32'h0);
      check(g_inst[1].ov == 1'b1, "R9 pass-through first cycle", 32'(g_inst[1].ov), 32'h1);
      while (!((fin[0][0] == f) && (fin[0][1] == f) && (fin[0][2] == f) && (fin[0][3] == f) &&
               (fin[1][0] == f) && (fin[1][1] == f) && (fin[1][2] == f) && (fin[1][3] == f) &&
               (expq[0].size() == 0) && (expq[1].size() == 0))) begin
        @(negedge clk);
      end
      or_pat_en = 1'b0;
      repeat (3) @(negedge clk);
      // R7: idle allocation held at the last finished packet's input
      check(g_inst[0].ir == 4'(1 << prev_m[0]), "R7 idle hold (rotate)", 32'(g_inst[0].ir), 32'(1 << prev_m[0]));
      check(g_inst[1].ir == 4'(1 << prev_m[1]), "R7 idle hold (fixed)", 32'(g_inst[1].ir), 32'(1 << prev_m[1]));
      check(g_inst[0].ov == 1'b0, "R8 no output when idle", 32'(g_inst[0].ov), 32'h0);
    end

    check(expq[0].size() == 0, "R8 all beats seen (rotate)", 32'(expq[0].size()), 32'h0);
    check(expq[1].size() == 0, "R8 all beats seen (fixed)", 32'(expq[1].size()), 32'h0);
    report();
    $finish;
  end

endmodule